// File: doc/BRIEF.md
# Audio master clock mode selector

This block produces the clocks that a digital audio receiver hands to its converters and other peripherals. The master clock comes from one of three sources. The first is the recovered clock of the receiver PLL, running at 256 times the sample rate. The second is that same clock halved, giving 128 times the sample rate. The third is a fixed free-run clock made by halving the 24.576 MHz crystal, which gives 12.288 MHz. The choice depends on the PLL lock state, a force bit, a two-bit lock-mode field and the double-rate flag. Normal rate spans 32 to 48 kHz and double rate spans 64 to 96 kHz.

From whichever master clock is in use, the block derives three more clocks: a bit clock at 64fs, a word clock at fs, and a 128fs clock. It also drives a free-run flag, which downstream logic uses to mute the data path, and a double-rate indicator. The PLL itself lies outside the block. It appears only as the recovered clock input and the lock and rate flags, which the block synchronizes into the crystal domain. Changes between sources pass through a handoff that leaves no short pulses on the master clock.

Top module: `amclk_sel`

## Requirements
- R1: While the lock input is low, the master clock is the crystal clock divided by two (period 2 x crystal period) and the free-run source is selected.
- R2: While locked with the force bit high, the master clock is the crystal clock divided by two, whatever the lock-mode and rate inputs are.
- R3: While locked, with the force bit low and lock mode 2'b00, the master clock is the recovered 256fs clock at both normal and double rate.
- R4: While locked, with the force bit low and lock mode 2'b01, the master clock is the recovered clock at normal rate and the recovered clock divided by two (128fs) at double rate.
- R5: While locked, with the force bit low and lock mode 2'b10 or 2'b11, the master clock is the recovered clock at normal rate and the crystal clock divided by two at double rate.
- R6: free_run_o is high exactly when the crystal-derived clock is the selected master source, and low otherwise.
- R7: When the master clock runs at 256fs (including free-run, taken as 256fs), bclk_o is master/4, clk128_o is master/2 and wclk_o is master/256.
- R8: When the master clock is 128fs, clk128_o equals the master clock, bclk_o is master/2 (still 64fs) and wclk_o is master/128.
- R9: dbl_rate_o is high only when the block is locked, the double-rate input is high and free-run is not active; otherwise it is low.
- R10: No high or low pulse on mclk_o is shorter than the narrowest half period among the source clocks, including across source changes.
- R11: While rst_ni is low, mclk_o, bclk_o, wclk_o, clk128_o and dbl_rate_o are low and free_run_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk_i | input | 1 | 24.576 MHz crystal clock, also the control domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rec_clk_i | input | 1 | Recovered 256fs clock from the receiver PLL |
| lock_i | input | 1 | PLL locked (active high), asynchronous |
| dbl_rate_i | input | 1 | PLL locked at double rate, asynchronous |
| force_free_i | input | 1 | Force the free-run clock while locked |
| lock_mode_i | input | 2 | Lock-mode table select (00, 01, 1x) |
| mclk_o | output | 1 | Selected master clock |
| bclk_o | output | 1 | Bit clock, 64fs |
| wclk_o | output | 1 | Word clock, fs |
| clk128_o | output | 1 | 128fs clock |
| dbl_rate_o | output | 1 | Double-rate indicator |
| free_run_o | output | 1 | Free-run mode flag |

## Verification
The assertions take two things for granted. First, the configuration inputs change seldom, so the selection register moves to a new source only once the previous handoff has completed in every source domain. Second, the recovered clock keeps toggling while a change is under way, so the clock being left can always release its enable. The stimulus respects both. It changes all control inputs together in a single time step, then holds the configuration for several word-clock periods. It keeps the modelled recovered clock running at all times, at 256 times 44.1 kHz for normal rate and 256 times 88.2 kHz for double rate.

// File: rtl/amclk_pkg.sv
`timescale 1ns/1ps
package amclk_pkg;
  localparam int unsigned NSRC  = 3;
  localparam int unsigned SRC_W = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_REC256 = 2'd0,
    SRC_REC128 = 2'd1,
    SRC_FREE   = 2'd2
  } src_e;

  localparam logic [1:0] LM_FULL = 2'b00;
  localparam logic [1:0] LM_HALF = 2'b01;
endpackage

// File: rtl/amclk_sync.sv
`timescale 1ns/1ps
module amclk_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) pipe_q[s] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/amclk_mode_dec.sv
`timescale 1ns/1ps
module amclk_mode_dec
  import amclk_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic       dbl_i,
  input  logic       force_i,
  input  logic [1:0] lm_i,
  output src_e       sel_o,
  output logic       free_o,
  output logic       dbl_o
);
  src_e sel_d;

  always_comb begin
    sel_d = SRC_REC256;
    if (!lock_i || force_i) begin
      sel_d = SRC_FREE;
    end else begin
      case (lm_i)
        LM_FULL: sel_d = SRC_REC256;
        LM_HALF: sel_d = dbl_i ? SRC_REC128 : SRC_REC256;
        default: sel_d = dbl_i ? SRC_FREE : SRC_REC256;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_o  <= SRC_FREE;
      free_o <= 1'b1;
      dbl_o  <= 1'b0;
    end else begin
      sel_o  <= sel_d;
      free_o <= (sel_d == SRC_FREE);
      dbl_o  <= lock_i && dbl_i && (sel_d != SRC_FREE);
    end
  end
endmodule

// File: rtl/amclk_gf_mux.sv
`timescale 1ns/1ps
// N-way clock mux: a source opens only after every other enable has closed.
module amclk_gf_mux #(
  parameter int unsigned N      = 3,
  parameter int unsigned SW     = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic [N-1:0]  src_i,
  input  logic          rst_ni,
  input  logic [SW-1:0] sel_i,
  output logic          clk_o,
  output logic [N-1:0]  en_o
);
  logic [N-1:0] gated;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic [STAGES-1:0] req_q;
    logic              en_q;
    logic              want;

    assign want = (sel_i == SW'(g)) && ((en_o & ~(N'(1) << g)) == '0);

    always_ff @(posedge src_i[g] or negedge rst_ni) begin
      if (!rst_ni) req_q <= '0;
      else         req_q <= {req_q[STAGES-2:0], want};
    end

    // enable moves only while the source is low
    always_ff @(negedge src_i[g] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= req_q[STAGES-1];
    end

    assign en_o[g]  = en_q;
    assign gated[g] = src_i[g] & en_q;
  end

  assign clk_o = |gated;
endmodule

// File: rtl/amclk_div.sv
`timescale 1ns/1ps
module amclk_div #(
  parameter int unsigned MCLK_PER_FS = 256,
  parameter int unsigned BCLK_PER_FS = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  output logic bclk_o,
  output logic wclk_o,
  output logic clk128_o
);
  localparam int unsigned CNT_W = $clog2(MCLK_PER_FS);
  localparam int unsigned BIT_B = $clog2(MCLK_PER_FS / BCLK_PER_FS) - 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CNT_W'(1);
  end

  assign bclk_o   = half_i ? cnt_q[BIT_B-1] : cnt_q[BIT_B];
  assign wclk_o   = half_i ? cnt_q[CNT_W-2] : cnt_q[CNT_W-1];
  assign clk128_o = half_i ? clk_i          : cnt_q[0];
endmodule

// File: rtl/amclk_sel.sv
`timescale 1ns/1ps
module amclk_sel
  import amclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MCLK_PER_FS = 256,
  parameter int unsigned BCLK_PER_FS = 64
) (
  input  logic       xtal_clk_i,
  input  logic       rst_ni,
  input  logic       rec_clk_i,
  input  logic       lock_i,
  input  logic       dbl_rate_i,
  input  logic       force_free_i,
  input  logic [1:0] lock_mode_i,
  output logic       mclk_o,
  output logic       bclk_o,
  output logic       wclk_o,
  output logic       clk128_o,
  output logic       dbl_rate_o,
  output logic       free_run_o
);
  localparam int unsigned CFG_W = 5;

  logic [CFG_W-1:0] cfg_s;
  logic             lock_s, dbl_s, force_s;
  logic [1:0]       lm_s;
  src_e             sel;
  logic             free_clk_q, half_clk_q;
  logic [NSRC-1:0]  src_clk, src_en;
  logic             half_req, half_s;

  amclk_sync #(.WIDTH(CFG_W), .STAGES(SYNC_STAGES)) u_cfg_sync (
    .clk_i  (xtal_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({lock_i, dbl_rate_i, force_free_i, lock_mode_i}),
    .q_o    (cfg_s)
  );
  assign {lock_s, dbl_s, force_s, lm_s} = cfg_s;

  amclk_mode_dec u_dec (
    .clk_i   (xtal_clk_i),
    .rst_ni  (rst_ni),
    .lock_i  (lock_s),
    .dbl_i   (dbl_s),
    .force_i (force_s),
    .lm_i    (lm_s),
    .sel_o   (sel),
    .free_o  (free_run_o),
    .dbl_o   (dbl_rate_o)
  );

  always_ff @(posedge xtal_clk_i or negedge rst_ni) begin
    if (!rst_ni) free_clk_q <= 1'b0;
    else         free_clk_q <= ~free_clk_q;
  end

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) half_clk_q <= 1'b0;
    else         half_clk_q <= ~half_clk_q;
  end

  // bit order follows src_e
  assign src_clk = {free_clk_q, half_clk_q, rec_clk_i};

  amclk_gf_mux #(.N(NSRC), .SW(SRC_W), .STAGES(SYNC_STAGES)) u_mux (
    .src_i  (src_clk),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .clk_o  (mclk_o),
    .en_o   (src_en)
  );

  assign half_req = (sel == SRC_REC128);

  amclk_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_half_sync (
    .clk_i  (mclk_o),
    .rst_ni (rst_ni),
    .d_i    (half_req),
    .q_o    (half_s)
  );

  amclk_div #(.MCLK_PER_FS(MCLK_PER_FS), .BCLK_PER_FS(BCLK_PER_FS)) u_div (
    .clk_i    (mclk_o),
    .rst_ni   (rst_ni),
    .half_i   (half_s),
    .bclk_o   (bclk_o),
    .wclk_o   (wclk_o),
    .clk128_o (clk128_o)
  );
endmodule

// File: rtl/amclk_sel_chk.sv
`timescale 1ns/1ps
module amclk_sel_chk
  import amclk_pkg::*;
(
  input logic            xtal_clk_i,
  input logic            rst_ni,
  input logic            lock_s,
  input logic            dbl_s,
  input logic            force_s,
  input logic [1:0]      lm_s,
  input logic [1:0]      sel,
  input logic [NSRC-1:0] src_en,
  input logic            free_run_o,
  input logic            dbl_rate_o
);
  AST_UNLOCK_FREE: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    !lock_s |=> free_run_o && sel == SRC_FREE); // R1
  AST_FORCE_FREE: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    lock_s && force_s |=> free_run_o); // R2
  AST_LM_FULL: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    lock_s && !force_s && lm_s == 2'b00 |=> sel == SRC_REC256 && !free_run_o); // R3
  AST_LM_HALF_DBL: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    lock_s && !force_s && lm_s == 2'b01 && dbl_s |=> sel == SRC_REC128); // R4
  AST_LM_HI_DBL: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    lock_s && !force_s && lm_s[1] && dbl_s |=> free_run_o && !dbl_rate_o); // R5
  AST_FLAG_MATCH: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    free_run_o == (sel == SRC_FREE)); // R6
  AST_DBL_EXCL: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    dbl_rate_o |-> !free_run_o); // R9
  AST_ONE_SOURCE: assert property (@(posedge xtal_clk_i) disable iff (!rst_ni)
    $onehot0(src_en)); // R10
endmodule

bind amclk_sel amclk_sel_chk u_chk (
  .xtal_clk_i (xtal_clk_i),
  .rst_ni     (rst_ni),
  .lock_s     (lock_s),
  .dbl_s      (dbl_s),
  .force_s    (force_s),
  .lm_s       (lm_s),
  .sel        (sel),
  .src_en     (src_en),
  .free_run_o (free_run_o),
  .dbl_rate_o (dbl_rate_o)
);

// File: tb/amclk_sel_tb.sv
`timescale 1ns/1ps
module amclk_sel_tb;
  localparam real XTAL_PER_NS = 40.690;
  localparam real REC_NORM_NS = 88.577;
  localparam real REC_DBL_NS  = 44.289;
  localparam real TOL         = 0.01;
  localparam real MIN_PULSE   = 20.0;

  logic       xtal_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic       lock = 1'b0, dbl = 1'b0, force_free = 1'b0;
  logic [1:0] lm = 2'b00;
  logic       mclk, bclk, wclk, clk128, dbl_rate, free_run;
  real        rec_per = REC_NORM_NS;

  int total = 0, bad = 0;
  bit done = 1'b0, arm = 1'b0;

  real t_m = 0.0, p_m = 0.0, t_b = 0.0, p_b = 0.0;
  real t_w = 0.0, p_w = 0.0, t_c = 0.0, p_c = 0.0;
  real t_rise = 0.0, t_fall = 0.0, min_pulse = 1.0e9;

  amclk_sel u_dut (
    .xtal_clk_i   (xtal_clk),
    .rst_ni       (rst_n),
    .rec_clk_i    (rec_clk),
    .lock_i       (lock),
    .dbl_rate_i   (dbl),
    .force_free_i (force_free),
    .lock_mode_i  (lm),
    .mclk_o       (mclk),
    .bclk_o       (bclk),
    .wclk_o       (wclk),
    .clk128_o     (clk128),
    .dbl_rate_o   (dbl_rate),
    .free_run_o   (free_run)
  );

  always #(XTAL_PER_NS / 2.0) xtal_clk = ~xtal_clk;
  always begin
    #(rec_per / 2.0);
    rec_clk = ~rec_clk;
  end

  always @(posedge mclk) begin
    p_m = $realtime - t_m; t_m = $realtime;
    if (arm && t_fall > 0.0 && ($realtime - t_fall) < min_pulse) min_pulse = $realtime - t_fall;
    t_rise = $realtime;
  end
  always @(negedge mclk) begin
    if (arm && t_rise > 0.0 && ($realtime - t_rise) < min_pulse) min_pulse = $realtime - t_rise;
    t_fall = $realtime;
  end
  always @(posedge bclk)   begin p_b = $realtime - t_b; t_b = $realtime; end
  always @(posedge wclk)   begin p_w = $realtime - t_w; t_w = $realtime; end
  always @(posedge clk128) begin p_c = $realtime - t_c; t_c = $realtime; end

  task automatic chk_real(input string req, input string what, input real act, input real exp);
    total++;
    if (act < exp * (1.0 - TOL) || act > exp * (1.0 + TOL)) begin
      bad++;
      $display("FAIL %s %s period act=%0.3f exp=%0.3f", req, what, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  initial begin
    #(XTAL_PER_NS * 5.3);
    chk_bit("R11", "mclk in reset", mclk, 1'b0);
    chk_bit("R11", "bclk in reset", bclk, 1'b0);
    chk_bit("R11", "wclk in reset", wclk, 1'b0);
    chk_bit("R11", "clk128 in reset", clk128, 1'b0);
    chk_bit("R11", "free_run in reset", free_run, 1'b1);
    chk_bit("R11", "dbl_rate in reset", dbl_rate, 1'b0);
    rst_n = 1'b1;
    arm   = 1'b1;

    for (int l = 0; l < 2; l++) begin
      for (int f = 0; f < 2; f++) begin
        for (int m = 0; m < 4; m++) begin
          for (int d = 0; d < 2; d++) begin
            bit    fr, half, exp_dbl;
            real   mper, fsper;
            string rq;
            lock       = l[0];
            force_free = f[0];
            lm         = m[1:0];
            dbl        = d[0];
            rec_per    = d ? REC_DBL_NS : REC_NORM_NS;
            fr      = (l == 0) || (f == 1) || (m >= 2 && d == 1);
            half    = !fr && m == 1 && d == 1;
            exp_dbl = (l == 1) && (d == 1) && !fr;
            mper    = fr ? 2.0 * XTAL_PER_NS : (half ? 2.0 * rec_per : rec_per);
            fsper   = fr ? 256.0 * 2.0 * XTAL_PER_NS : 256.0 * rec_per;
            rq = (l == 0) ? "R1" : (f == 1) ? "R2" : (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
            #(3.0 * fsper + 2000.0);
            chk_real(rq, "mclk", p_m, mper);
            chk_real(half ? "R8" : "R7", "bclk", p_b, fsper / 64.0);
            chk_real(half ? "R8" : "R7", "wclk", p_w, fsper);
            chk_real(half ? "R8" : "R7", "clk128", p_c, fsper / 128.0);
            chk_bit("R6", "free_run", free_run, fr);
            chk_bit("R9", "dbl_rate", dbl_rate, exp_dbl);
          end
        end
      end
    end

    total++;
    if (min_pulse < MIN_PULSE) begin
      bad++;
      $display("FAIL R10 shortest mclk pulse act=%0.3f exp>=%0.3f", min_pulse, MIN_PULSE);
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000.0 * XTAL_PER_NS);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule